// File: doc/BRIEF.md
# Debug Test Access Port with Scan-Chain Selection

This block is the target-side serial debug port of a processor. A standard sixteen-state test access port controller, clocked by `tck` and steered by `tms`, moves scans through a 4-bit instruction register and a set of data paths. The data paths are a one-bit bypass stage, a 32-bit identification register, a 4-bit scan-chain select register, and two debug chains. The 33-bit chain carries an instruction word plus a breakpoint flag toward the core. The 38-bit chain carries a data word, a register address and a direction flag toward the debug registers. A debugger first loads the chain-select instruction and shifts a chain number. It then loads one of the two test instructions, and later scans run through the chosen chain.

Every data register captures in Capture-DR, shifts least significant bit first, and presents its result in Update-DR. The chain contents come from `chain1_cap` / `chain2_cap` and are handed back on `chain1_q` / `chain2_q`. Whatever sits outside the block decides what these fields mean. The block gives the surrounding logic two single-cycle events, and each fires as the controller enters Run-Test/Idle. One is a restart request to the core. The other is a debug-clock pulse that steps an instruction injected through chain 1. All interfaces are plain serial or level signals, so there is no valid/ready handshake and no back-pressure.

Top module: `dbg_tap`

## Requirements
- R1: From any state, five rising `tck` edges with `tms` high reach Test-Logic-Reset, and one further edge with `tms` low reaches Run-Test/Idle. Test-Logic-Reset sets the instruction to IDCODE and the chain select to 0, and so does a low `trst_n`.
- R2: The instruction register is 4 bits and shifts least significant bit first. Capture-IR loads 4'b0001, so the first four `tdo` bits of any IR scan are 1,0,0,0.
- R3: With IDCODE (4'hE) selected, a 32-bit DR scan returns the identification value, least significant bit first.
- R4: With BYPASS (4'hF) selected, the path is one bit long and captures 0. Output bit k of a scan equals input bit k-1, and output bit 0 is 0.
- R5: The chain-select instruction (4'h2) connects a 4-bit register that captures the current `chain_sel` and shifts least significant bit first. Its shifted value appears on `chain_sel` at Update-DR. No other path and no other state changes `chain_sel`.
- R6: Under INTEST (4'hC) or EXTEST (4'h0) with `chain_sel`=1, DR scans use a 33-bit chain. It captures `chain1_cap` and shows the shifted value on `chain1_q` after Update-DR.
- R7: Under INTEST or EXTEST with `chain_sel`=2, DR scans use a 38-bit chain. It captures `chain2_cap` and shows the shifted value on `chain2_q` after Update-DR.
- R8: `restart_pulse` is high for exactly one `tck` cycle each time the controller enters Run-Test/Idle while the RESTART instruction (4'h4) is in effect, including the Update-IR that loads it.
- R9: `dbg_clk_pulse` is high for one cycle on each entry into Run-Test/Idle under INTEST with `chain_sel`=1, and never under any other instruction or chain.
- R10: `tdo` changes only on falling `tck` edges. `tdo_en` is high exactly in the cycles spent in Shift-IR or Shift-DR.
- R11: CLAMP (4'h5), HIGHZ (4'h7), CLAMPZ (4'h9), RESTART, any unlisted code, and the test instructions with a chain number other than 1 or 2 all select the bypass path.
- R12: `capture_dr`, `shift_dr` and `update_dr` are each high for exactly the cycles the controller spends in Capture-DR, Shift-DR and Update-DR. An n-bit DR scan gives 1, n and 1 such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| chain1_cap | input | C1_W | Value captured into chain 1 |
| chain2_cap | input | C2_W | Value captured into chain 2 |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` (drive only while shifting) |
| capture_dr | output | 1 | Controller is in Capture-DR |
| shift_dr | output | 1 | Controller is in Shift-DR |
| update_dr | output | 1 | Controller is in Update-DR |
| chain_sel | output | SEL_W | Active scan-chain number |
| chain1_q | output | C1_W | Chain 1 contents latched at Update-DR |
| chain2_q | output | C2_W | Chain 2 contents latched at Update-DR |
| restart_pulse | output | 1 | One-cycle restart request to the core |
| dbg_clk_pulse | output | 1 | One-cycle debug-clock step for injected instructions |

## Verification
The bench builds the block with its default chain lengths of 33 and 38 bits and a 4-bit select. Full-length scans of both chains therefore check the exact bit count, because an off-by-one length shifts every returned bit. It overrides the identification value with 32'h5A3C_96E1, a pattern that is not symmetric, so a reversed or mis-aligned IDCODE scan cannot match it by chance. The select width of 4 makes the unused chain number 3 reachable, and the bench uses it to check the fall-back to bypass.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_CHSEL   = 4'h2;
  localparam logic [IR_W-1:0] OP_RESTART = 4'h4;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'h5;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'h7;
  localparam logic [IR_W-1:0] OP_CLAMPZ  = 4'h9;
  localparam logic [IR_W-1:0] OP_INTEST  = 4'hC;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'hE;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [2:0] {
    PATH_BYP, PATH_ID, PATH_SEL, PATH_C1, PATH_C2
  } dr_path_e;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st,
  output tap_state_e nxt
);

  always_comb begin
    nxt = st;
    unique case (st)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= S_TLR;
    else         st <= nxt;
  end

  // Run length of consecutive high tms samples, saturating at five.
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && ones_q >= 3'd4) |=> (st == S_TLR));

endmodule

// File: rtl/dbg_tap_dr_reg.sv
module dbg_tap_dr_reg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         clr,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         upd,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic         so,
  output logic [W-1:0] q
);

  logic [W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          sr <= '0;
    else if (sel && cap)  sr <= cap_val;
    else if (sel && shf)  sr <= {tdi, sr[W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         q <= '0;
    else if (clr)        q <= '0;
    else if (sel && upd) q <= sr;
  end

  assign so = sr[0];

  // R5, R6, R7: the parallel value moves only at its own update or a clear.
  p_upd_only_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (!(sel && upd) && !clr) |=> $stable(q));

endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
  import dbg_tap_pkg::*;
#(
  parameter int          SEL_W  = 4,
  parameter int          C1_W   = 33,
  parameter int          C2_W   = 38,
  parameter logic [31:0] ID_VAL = 32'h1F0F_0F0F
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [C1_W-1:0]  chain1_cap,
  input  logic [C2_W-1:0]  chain2_cap,
  output logic             tdo,
  output logic             tdo_en,
  output logic             capture_dr,
  output logic             shift_dr,
  output logic             update_dr,
  output logic [SEL_W-1:0] chain_sel,
  output logic [C1_W-1:0]  chain1_q,
  output logic [C2_W-1:0]  chain2_q,
  output logic             restart_pulse,
  output logic             dbg_clk_pulse
);

  localparam int ID_W = $bits(ID_VAL);
  localparam logic [SEL_W-1:0] SEL_C1 = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_C2 = SEL_W'(2);

  tap_state_e st, nxt;

  dbg_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .st     (st),
    .nxt    (nxt)
  );

  logic in_tlr;
  assign in_tlr     = (st == S_TLR);
  assign capture_dr = (st == S_CAP_DR);
  assign shift_dr   = (st == S_SH_DR);
  assign update_dr  = (st == S_UPD_DR);

  // Instruction register: shift stage and held instruction.
  logic [IR_W-1:0] ir_sr, ir;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
      ir    <= OP_IDCODE;
    end else begin
      if (st == S_CAP_IR)     ir_sr <= IR_CAPTURE;
      else if (st == S_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (in_tlr)              ir <= OP_IDCODE;
      else if (st == S_UPD_IR) ir <= ir_sr;
    end
  end

  // Data path decode.
  dr_path_e path;
  always_comb begin
    unique case (ir)
      OP_IDCODE: path = PATH_ID;
      OP_CHSEL:  path = PATH_SEL;
      OP_INTEST, OP_EXTEST:
        path = (chain_sel == SEL_C1) ? PATH_C1 :
               (chain_sel == SEL_C2) ? PATH_C2 : PATH_BYP;
      default:   path = PATH_BYP;
    endcase
  end

  // Bypass stage and identification register.
  logic            byp_q;
  logic [ID_W-1:0] id_sr;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sr <= ID_VAL;
    end else begin
      if (path == PATH_BYP && capture_dr)    byp_q <= 1'b0;
      else if (path == PATH_BYP && shift_dr) byp_q <= tdi;
      if (path == PATH_ID && capture_dr)     id_sr <= ID_VAL;
      else if (path == PATH_ID && shift_dr)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  // Select register and the two debug chains share one register shape.
  logic so_sel, so_c1, so_c2;

  dbg_tap_dr_reg #(.W(SEL_W)) u_sel (
    .tck (tck), .trst_n (trst_n), .clr (in_tlr), .sel (path == PATH_SEL),
    .cap (capture_dr), .shf (shift_dr), .upd (update_dr), .tdi (tdi),
    .cap_val (chain_sel), .so (so_sel), .q (chain_sel)
  );

  dbg_tap_dr_reg #(.W(C1_W)) u_chain1 (
    .tck (tck), .trst_n (trst_n), .clr (in_tlr), .sel (path == PATH_C1),
    .cap (capture_dr), .shf (shift_dr), .upd (update_dr), .tdi (tdi),
    .cap_val (chain1_cap), .so (so_c1), .q (chain1_q)
  );

  dbg_tap_dr_reg #(.W(C2_W)) u_chain2 (
    .tck (tck), .trst_n (trst_n), .clr (in_tlr), .sel (path == PATH_C2),
    .cap (capture_dr), .shf (shift_dr), .upd (update_dr), .tdi (tdi),
    .cap_val (chain2_cap), .so (so_c2), .q (chain2_q)
  );

  // Serial return mux.
  logic so;
  always_comb begin
    if (st == S_SH_IR) so = ir_sr[0];
    else begin
      unique case (path)
        PATH_ID:  so = id_sr[0];
        PATH_SEL: so = so_sel;
        PATH_C1:  so = so_c1;
        PATH_C2:  so = so_c2;
        default:  so = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= so;
      tdo_en <= (st == S_SH_IR) || (st == S_SH_DR);
    end
  end

  // Run-Test/Idle entry events; the instruction loaded by this Update-IR counts.
  logic [IR_W-1:0] ir_eff;
  logic            enter_rti;
  assign ir_eff    = (st == S_UPD_IR) ? ir_sr : ir;
  assign enter_rti = (nxt == S_RTI) && (st != S_RTI);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      restart_pulse <= 1'b0;
      dbg_clk_pulse <= 1'b0;
    end else begin
      restart_pulse <= enter_rti && (ir_eff == OP_RESTART);
      dbg_clk_pulse <= enter_rti && (ir_eff == OP_INTEST) && (chain_sel == SEL_C1);
    end
  end

  p_tdo_en_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == ((st == S_SH_IR) || (st == S_SH_DR)));

  p_restart_single_r8: assert property (@(posedge tck) disable iff (!trst_n)
    restart_pulse |=> !restart_pulse);

  p_restart_src_r8: assert property (@(posedge tck) disable iff (!trst_n)
    restart_pulse |-> (st == S_RTI && ir == OP_RESTART));

  p_dbgclk_src_r9: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_clk_pulse |-> (st == S_RTI && ir == OP_INTEST && chain_sel == SEL_C1));

  p_ir_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_TLR) |=> (ir == OP_IDCODE && chain_sel == '0));

endmodule

// File: tb/dbg_tap_tb.sv
module dbg_tap_tb;

  localparam int          C1_W = 33;
  localparam int          C2_W = 38;
  localparam logic [31:0] ID   = 32'h5A3C_96E1;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [C1_W-1:0] c1cap = 33'h1_89AB_CDEF;
  logic [C2_W-1:0] c2cap = 38'h2A_5566_7788;
  logic tdo, tdo_en, capture_dr, shift_dr, update_dr, restart_pulse, dbg_clk_pulse;
  logic [3:0] chain_sel;
  logic [C1_W-1:0] chain1_q;
  logic [C2_W-1:0] chain2_q;

  always #5 tck = ~tck;

  dbg_tap #(.SEL_W(4), .C1_W(C1_W), .C2_W(C2_W), .ID_VAL(ID)) u_dut (
    .tck (tck), .trst_n (trst_n), .tms (tms), .tdi (tdi),
    .chain1_cap (c1cap), .chain2_cap (c2cap),
    .tdo (tdo), .tdo_en (tdo_en), .capture_dr (capture_dr), .shift_dr (shift_dr),
    .update_dr (update_dr), .chain_sel (chain_sel), .chain1_q (chain1_q),
    .chain2_q (chain2_q), .restart_pulse (restart_pulse), .dbg_clk_pulse (dbg_clk_pulse)
  );

  int nchk = 0, nerr = 0;
  int rcnt = 0, dcnt = 0, ncap = 0, nsh = 0, nupd = 0, nen = 0, hold_err = 0;
  bit done = 1'b0;

  // instruction code, bypass input byte, expected output byte
  localparam logic [19:0] BYP_TABLE [6] = '{
    {4'hF, 8'hA5, 8'h4A},
    {4'h5, 8'h3C, 8'h78},
    {4'h7, 8'h81, 8'h02},
    {4'h9, 8'hFF, 8'hFE},
    {4'h1, 8'h5A, 8'hB4},
    {4'h4, 8'hC3, 8'h86}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d, output logic o);
    tms = t;
    tdi = d;
    o = tdo;
    if (restart_pulse) rcnt++;
    if (dbg_clk_pulse) dcnt++;
    if (capture_dr)    ncap++;
    if (shift_dr)      nsh++;
    if (update_dr)     nupd++;
    if (tdo_en)        nen++;
    @(posedge tck);
    #1;
    if (tdo !== o) hold_err++;
    @(negedge tck);
    #2;
  endtask

  task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic dr_scan(input logic [63:0] din, input int n, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [3:0]  irc;
    logic [63:0] dout;
    logic        o;
    int          r0, d0;

    repeat (2) @(negedge tck);
    #2;
    // R1, R10: reset state
    chk("R10 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
    chk("R1 chain_sel in reset", {60'd0, chain_sel}, 64'd0);
    chk("R8 R9 pulses in reset", {62'd0, restart_pulse, dbg_clk_pulse}, 64'd0);
    chk("R12 strobes in reset", {61'd0, capture_dr, shift_dr, update_dr}, 64'd0);
    trst_n = 1'b1;

    repeat (5) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk("R10 tdo_en idle", {63'd0, tdo_en}, 64'd0);

    // R3, R12, R10: IDCODE after reset
    ncap = 0; nsh = 0; nupd = 0; nen = 0;
    dr_scan(64'd0, 32, dout);
    chk("R3 idcode scan", dout, {32'd0, ID});
    chk("R12 strobe counts", {ncap[15:0], nsh[15:0], nupd[15:0]}, {16'd1, 16'd32, 16'd1});
    chk("R10 tdo_en cycles", 64'(nen), 64'd32);

    // R2, R4, R11: table of bypass-path instructions
    foreach (BYP_TABLE[k]) begin
      ir_scan(BYP_TABLE[k][19:16], irc);
      chk("R2 ir capture", {60'd0, irc}, 64'h1);
      dr_scan({56'd0, BYP_TABLE[k][15:8]}, 8, dout);
      chk("R4 R11 bypass path", dout, {56'd0, BYP_TABLE[k][7:0]});
    end

    // R8: restart pulse per entry into idle
    r0 = rcnt;
    ir_scan(4'h4, irc);
    repeat (3) step(1'b0, 1'b0, o);
    chk("R8 restart once on load", 64'(rcnt - r0), 64'd1);
    dr_scan(64'd0, 3, dout);
    chk("R8 restart on re-entry", 64'(rcnt - r0), 64'd2);

    // R5: chain select load and readback
    ir_scan(4'h2, irc);
    dr_scan(64'h1, 4, dout);
    chk("R5 select capture old", dout, 64'h0);
    chk("R5 chain_sel loaded", {60'd0, chain_sel}, 64'h1);
    dr_scan(64'h1, 4, dout);
    chk("R5 select readback", dout, 64'h1);

    // R6, R9: chain 1 under INTEST
    ir_scan(4'hC, irc);
    chk("R5 chain_sel unchanged by IR", {60'd0, chain_sel}, 64'h1);
    d0 = dcnt;
    dr_scan({31'd0, 33'h0_1357_9BDF}, C1_W, dout);
    chk("R6 chain1 capture", dout, {31'd0, c1cap});
    chk("R6 chain1 update", {31'd0, chain1_q}, {31'd0, 33'h0_1357_9BDF});
    chk("R9 debug clock chain1", 64'(dcnt - d0), 64'd1);

    // R7, R9: chain 2 under EXTEST
    ir_scan(4'h2, irc);
    dr_scan(64'h2, 4, dout);
    chk("R5 select readback 1", dout, 64'h1);
    ir_scan(4'h0, irc);
    d0 = dcnt;
    dr_scan({26'd0, 38'h15_0F0F_1234}, C2_W, dout);
    chk("R7 chain2 capture", dout, {26'd0, c2cap});
    chk("R7 chain2 update", {26'd0, chain2_q}, {26'd0, 38'h15_0F0F_1234});
    chk("R9 no debug clock chain2", 64'(dcnt - d0), 64'd0);

    // R11: unused chain number falls back to bypass
    ir_scan(4'h2, irc);
    dr_scan(64'h3, 4, dout);
    ir_scan(4'hC, irc);
    d0 = dcnt;
    dr_scan(64'hA5, 8, dout);
    chk("R11 unused chain bypass", dout, 64'h4A);
    chk("R9 no debug clock chain3", 64'(dcnt - d0), 64'd0);

    // R1: tms reset from inside Shift-DR
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    repeat (5) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk("R1 chain_sel cleared", {60'd0, chain_sel}, 64'h0);
    dr_scan(64'd0, 32, dout);
    chk("R1 idcode after tms reset", dout, {32'd0, ID});

    chk("R10 tdo stable at rising edge", 64'(hold_err), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule